// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block is a small pool of waiting slots placed in front of one execution-unit class of an out-of-order core. Each slot keeps an operation code, two source operands and, for every operand not yet computed, the reorder-buffer index of the instruction that will produce it. Pending results are named only by reorder-buffer index, never by slot number. A slot also keeps the reorder-buffer index of its own result, so that it knows when to give itself up.

An instruction enters through the dispatch port. It is taken only when a slot is free and the reorder buffer reports a free entry in the same cycle. Every waiting slot listens to the result bus and copies a value whose tag matches an operand it is still missing. A slot whose two operands are both present can be sent to the execution unit. When several slots can go, the one with the lowest index goes first. A slot that has been sent stays occupied until its own result tag appears on the result bus. A flush input empties the whole pool in one cycle.

Top module: `resv_station`

## Requirements
- R1: `disp_ready_o` is 1 exactly when at least one slot is free and `rob_free_i` is 1. An instruction is accepted on a cycle with `disp_valid_i` and `disp_ready_o` both 1, and it takes the lowest-numbered free slot.
- R2: For each source operand, a ready flag of 1 at dispatch means the value field is used as the operand. A ready flag of 0 means the tag field holds the reorder-buffer index that is awaited.
- R3: If the result bus carries a tag that equals a not-ready source tag during the cycle in which that instruction is accepted, the bus data becomes that operand's value.
- R4: A slot waiting on an operand takes `cdb_data_i` when `cdb_valid_i` is 1 and `cdb_tag_i` equals the awaited tag. A broadcast with any other tag leaves that operand waiting.
- R5: `issue_valid_o` is 1 only when some occupied, not-yet-sent slot holds both operand values. It is 0 otherwise.
- R6: The issue port presents the lowest-indexed eligible slot, with its operation, destination tag and both operand values. A slot is sent on a cycle with `issue_valid_o` and `issue_ready_i` both 1. While the port is not accepted, `issue_valid_o` stays 1.
- R7: A sent slot stays occupied until a result-bus broadcast carries its destination tag. It is free from the next cycle.
- R8: When `flush_i` is 1, every slot is free in the next cycle, and an instruction offered in the same cycle is dropped.
- R9: After reset, all slots are free and `issue_valid_o` is 0. `cdb_ready_o` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty every slot |
| rob_free_i | input | 1 | Reorder buffer has a free entry |
| disp_valid_i | input | 1 | Dispatch request |
| disp_ready_o | output | 1 | Dispatch can be accepted |
| disp_op_i | input | OP_W | Operation code |
| disp_dest_i | input | TAG_W | Reorder-buffer index of the result |
| disp_a_rdy_i | input | 1 | Operand A carries a value |
| disp_a_tag_i | input | TAG_W | Producer tag of operand A |
| disp_a_val_i | input | DATA_W | Value of operand A |
| disp_b_rdy_i | input | 1 | Operand B carries a value |
| disp_b_tag_i | input | TAG_W | Producer tag of operand B |
| disp_b_val_i | input | DATA_W | Value of operand B |
| cdb_valid_i | input | 1 | Result broadcast present |
| cdb_ready_o | output | 1 | Broadcast accepted (constant 1) |
| cdb_tag_i | input | TAG_W | Tag of the broadcast result |
| cdb_data_i | input | DATA_W | Broadcast result value |
| issue_valid_o | output | 1 | A slot is offered to the execution unit |
| issue_ready_i | input | 1 | Execution unit takes the offer |
| issue_op_o | output | OP_W | Operation of the offered slot |
| issue_dest_o | output | TAG_W | Destination tag of the offered slot |
| issue_a_o | output | DATA_W | Operand A of the offered slot |
| issue_b_o | output | DATA_W | Operand B of the offered slot |

## Verification
A result broadcast and a dispatch can fall in the same cycle. When the broadcast tag matches a missing source of the incoming instruction, the slot must be written with the bus value instead of staying in wait. The bench provokes this by driving both ports in one cycle. It then judges the value that appears on the issue port once the slot is eligible, and it also compares every cycle of a long mixed run, in which dispatch, broadcast, issue and flush overlap freely, against an arithmetic model of the pool.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_SENT = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_first_one.sv
module rs_first_one #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = '0;
      if (req_i[i]) gnt_o[i] = 1'b1;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rs_operand.sv
module rs_operand #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ld_rdy_i,
  input  logic [TAG_W-1:0]  ld_tag_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              live_i,
  input  logic              cdb_v_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] val_o
);
  logic              rdy_q, rdy_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic              hit_ld, hit_cur;

  assign hit_ld  = cdb_v_i && (cdb_tag_i == ld_tag_i);
  assign hit_cur = live_i && !rdy_q && cdb_v_i && (cdb_tag_i == tag_q);

  always_comb begin
    rdy_d = rdy_q;
    tag_d = tag_q;
    val_d = val_q;
    if (load_i) begin
      rdy_d = ld_rdy_i || hit_ld;
      tag_d = ld_tag_i;
      val_d = ld_rdy_i ? ld_val_i : cdb_data_i;
    end else if (hit_cur) begin
      rdy_d = 1'b1;
      val_d = cdb_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      tag_q <= '0;
      val_q <= '0;
    end else if (load_i || hit_cur) begin
      rdy_q <= rdy_d;
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end

  assign rdy_o = rdy_q;
  assign val_o = val_q;

  assert_snoop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !rdy_q && cdb_v_i && cdb_tag_i == tag_q && !load_i)
      |=> (rdy_o && val_o == $past(cdb_data_i)));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ld_rdy_i && cdb_v_i && cdb_tag_i == ld_tag_i)
      |=> (rdy_o && val_o == $past(cdb_data_i)));
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [OP_W-1:0]   ld_op_i,
  input  logic [TAG_W-1:0]  ld_dest_i,
  input  logic              ld_a_rdy_i,
  input  logic [TAG_W-1:0]  ld_a_tag_i,
  input  logic [DATA_W-1:0] ld_a_val_i,
  input  logic              ld_b_rdy_i,
  input  logic [TAG_W-1:0]  ld_b_tag_i,
  input  logic [DATA_W-1:0] ld_b_val_i,
  input  logic              cdb_v_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              grant_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  dest_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  slot_state_e       st_q, st_d;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dest_q;
  logic              a_rdy, b_rdy, live, done_hit;

  assign live     = (st_q == SLOT_WAIT);
  assign done_hit = (st_q == SLOT_SENT) && cdb_v_i && (cdb_tag_i == dest_q);

  always_comb begin
    st_d = st_q;
    if (flush_i)                    st_d = SLOT_FREE;
    else if (load_i)                st_d = SLOT_WAIT;
    else if (live && grant_i)       st_d = SLOT_SENT;
    else if (done_hit)              st_d = SLOT_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SLOT_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      dest_q <= '0;
    end else if (load_i) begin
      op_q   <= ld_op_i;
      dest_q <= ld_dest_i;
    end
  end

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opa (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .ld_rdy_i(ld_a_rdy_i), .ld_tag_i(ld_a_tag_i), .ld_val_i(ld_a_val_i),
    .live_i(live), .cdb_v_i(cdb_v_i), .cdb_tag_i(cdb_tag_i),
    .cdb_data_i(cdb_data_i), .rdy_o(a_rdy), .val_o(a_o));

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opb (
    .clk(clk), .rst_n(rst_n), .load_i(load_i),
    .ld_rdy_i(ld_b_rdy_i), .ld_tag_i(ld_b_tag_i), .ld_val_i(ld_b_val_i),
    .live_i(live), .cdb_v_i(cdb_v_i), .cdb_tag_i(cdb_tag_i),
    .cdb_data_i(cdb_data_i), .rdy_o(b_rdy), .val_o(b_o));

  assign busy_o  = (st_q != SLOT_FREE);
  assign ready_o = live && a_rdy && b_rdy;
  assign op_o    = op_q;
  assign dest_o  = dest_q;

  assert_grant_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (a_rdy && b_rdy && busy_o));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_SENT && cdb_v_i && cdb_tag_i == dest_q) |=> !busy_o);

  assert_load_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_o);
endmodule

// File: rtl/resv_station.sv
module resv_station #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned TAG_W   = 3,
  parameter int unsigned OP_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              rob_free_i,
  input  logic              disp_valid_i,
  output logic              disp_ready_o,
  input  logic [OP_W-1:0]   disp_op_i,
  input  logic [TAG_W-1:0]  disp_dest_i,
  input  logic              disp_a_rdy_i,
  input  logic [TAG_W-1:0]  disp_a_tag_i,
  input  logic [DATA_W-1:0] disp_a_val_i,
  input  logic              disp_b_rdy_i,
  input  logic [TAG_W-1:0]  disp_b_tag_i,
  input  logic [DATA_W-1:0] disp_b_val_i,
  input  logic              cdb_valid_i,
  output logic              cdb_ready_o,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              issue_valid_o,
  input  logic              issue_ready_i,
  output logic [OP_W-1:0]   issue_op_o,
  output logic [TAG_W-1:0]  issue_dest_o,
  output logic [DATA_W-1:0] issue_a_o,
  output logic [DATA_W-1:0] issue_b_o
);
  logic [NUM_ENT-1:0] busy_vec, free_vec, alloc_vec, load_vec;
  logic [NUM_ENT-1:0] rdy_vec, pick_vec, grant_vec;
  logic               any_free, disp_fire;
  logic [OP_W-1:0]    e_op   [NUM_ENT];
  logic [TAG_W-1:0]   e_dest [NUM_ENT];
  logic [DATA_W-1:0]  e_a    [NUM_ENT];
  logic [DATA_W-1:0]  e_b    [NUM_ENT];

  assign free_vec     = ~busy_vec;
  assign disp_ready_o = any_free && rob_free_i;
  assign disp_fire    = disp_valid_i && disp_ready_o && !flush_i;
  assign load_vec     = alloc_vec & {NUM_ENT{disp_fire}};
  assign grant_vec    = pick_vec & {NUM_ENT{issue_ready_i}};
  assign cdb_ready_o  = 1'b1;

  rs_first_one #(.N(NUM_ENT)) u_alloc (
    .req_i(free_vec), .gnt_o(alloc_vec), .any_o(any_free));

  rs_first_one #(.N(NUM_ENT)) u_pick (
    .req_i(rdy_vec), .gnt_o(pick_vec), .any_o(issue_valid_o));

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .load_i(load_vec[g]),
      .ld_op_i(disp_op_i), .ld_dest_i(disp_dest_i),
      .ld_a_rdy_i(disp_a_rdy_i), .ld_a_tag_i(disp_a_tag_i), .ld_a_val_i(disp_a_val_i),
      .ld_b_rdy_i(disp_b_rdy_i), .ld_b_tag_i(disp_b_tag_i), .ld_b_val_i(disp_b_val_i),
      .cdb_v_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_data_i(cdb_data_i),
      .grant_i(grant_vec[g]), .busy_o(busy_vec[g]), .ready_o(rdy_vec[g]),
      .op_o(e_op[g]), .dest_o(e_dest[g]), .a_o(e_a[g]), .b_o(e_b[g]));
  end

  always_comb begin
    issue_op_o   = '0;
    issue_dest_o = '0;
    issue_a_o    = '0;
    issue_b_o    = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (pick_vec[i]) begin
        issue_op_o   = issue_op_o   | e_op[i];
        issue_dest_o = issue_dest_o | e_dest[i];
        issue_a_o    = issue_a_o    | e_a[i];
        issue_b_o    = issue_b_o    | e_b[i];
      end
    end
  end

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_offer_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid_o && !issue_ready_i && !flush_i) |=> issue_valid_o);

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (busy_vec == '0 && !issue_valid_o));

  assert_full_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_vec == '1) |-> !disp_ready_o);
endmodule

// File: tb/sim_resv_station.sv
`timescale 1ns/1ps
module sim_resv_station;
  localparam int NE = 4;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic flush, rob_free, dv, dr, ar, br, cv, cr, iv, ir;
  logic [OW-1:0] dop, iop;
  logic [TW-1:0] ddest, at, bt, ct, idest;
  logic [DW-1:0] av, bv, cd, ia, ib;

  resv_station u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .rob_free_i(rob_free),
    .disp_valid_i(dv), .disp_ready_o(dr), .disp_op_i(dop), .disp_dest_i(ddest),
    .disp_a_rdy_i(ar), .disp_a_tag_i(at), .disp_a_val_i(av),
    .disp_b_rdy_i(br), .disp_b_tag_i(bt), .disp_b_val_i(bv),
    .cdb_valid_i(cv), .cdb_ready_o(cr), .cdb_tag_i(ct), .cdb_data_i(cd),
    .issue_valid_o(iv), .issue_ready_i(ir), .issue_op_o(iop),
    .issue_dest_o(idest), .issue_a_o(ia), .issue_b_o(ib));

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model of the pool
  bit mv[NE], ms[NE], mar[NE], mbr[NE];
  logic [OW-1:0] mop[NE];
  logic [TW-1:0] md[NE], mat[NE], mbt[NE];
  logic [DW-1:0] mav[NE], mbv[NE];

  // snapshot of outputs of the last cycle
  logic s_dr, s_iv;
  logic [OW-1:0] s_op;
  logic [TW-1:0] s_dest;
  logic [DW-1:0] s_a, s_b;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; dv = 0; cv = 0; ir = 0;
    dop = '0; ddest = '0; ar = 0; at = '0; av = '0; br = 0; bt = '0; bv = '0;
    ct = '0; cd = '0;
  endtask

  task automatic cyc();
    int pick, alloc;
    bit e_dr, fire;
    pick = -1; alloc = -1;
    for (int i = NE - 1; i >= 0; i--) begin
      if (mv[i] && !ms[i] && mar[i] && mbr[i]) pick = i;
      if (!mv[i]) alloc = i;
    end
    e_dr = (alloc >= 0) && rob_free;
    #1;
    check("R1", dr, e_dr);
    check("R5", iv, pick >= 0);
    check("R9", cr, 1'b1);
    if (pick >= 0) begin
      check("R6", iop, mop[pick]);
      check("R6", idest, md[pick]);
      check("R6", ia, mav[pick]);
      check("R6", ib, mbv[pick]);
    end
    s_dr = dr; s_iv = iv; s_op = iop; s_dest = idest; s_a = ia; s_b = ib;
    fire = dv && e_dr;
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < NE; i++) mv[i] = 0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (mv[i] && !ms[i]) begin
          if (!mar[i] && cv && ct == mat[i]) begin mar[i] = 1; mav[i] = cd; end
          if (!mbr[i] && cv && ct == mbt[i]) begin mbr[i] = 1; mbv[i] = cd; end
          if (pick == i && ir) ms[i] = 1;
        end else if (mv[i] && ms[i] && cv && ct == md[i]) begin
          mv[i] = 0;
        end
      end
      if (fire) begin
        mv[alloc] = 1; ms[alloc] = 0; mop[alloc] = dop; md[alloc] = ddest;
        mat[alloc] = at; mbt[alloc] = bt;
        mar[alloc] = ar || (cv && ct == at);
        mav[alloc] = ar ? av : cd;
        mbr[alloc] = br || (cv && ct == bt);
        mbv[alloc] = br ? bv : cd;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin mv[i] = 0; ms[i] = 0; end
    rst_n = 0; rob_free = 1; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9: empty after reset
    cyc();
    check("R9", s_iv, 1'b0);
    check("R9", s_dr, 1'b1);

    // R2/R5: A given as value, B awaits tag 5
    dv = 1; dop = 4'h3; ddest = 3'd1; ar = 1; av = 16'h0011; br = 0; bt = 3'd5;
    cyc(); idle();
    cyc();
    check("R5", s_iv, 1'b0);

    // R4: broadcast with another tag first, then the awaited one
    cv = 1; ct = 3'd4; cd = 16'hdead;
    cyc(); idle();
    cyc();
    check("R4", s_iv, 1'b0);
    cv = 1; ct = 3'd5; cd = 16'h1234;
    cyc(); idle();
    cyc();
    check("R4", s_b, 16'h1234);
    check("R2", s_a, 16'h0011);
    check("R2", s_dest, 3'd1);

    // R3: dispatch and matching broadcast in the same cycle
    dv = 1; dop = 4'h2; ddest = 3'd2; ar = 0; at = 3'd6; br = 1; bv = 16'h0022;
    cv = 1; ct = 3'd6; cd = 16'h0abc;
    cyc(); idle();
    ir = 1;
    cyc();
    check("R6", s_dest, 3'd1);
    cyc();
    check("R3", s_dest, 3'd2);
    check("R3", s_a, 16'h0abc);
    idle();

    // R1/R7: fill the pool, then release a sent slot
    dv = 1; ar = 1; br = 1; ddest = 3'd3; av = 16'h0003; bv = 16'h0030;
    cyc();
    ddest = 3'd4;
    cyc(); idle();
    cyc();
    check("R1", s_dr, 1'b0);
    cv = 1; ct = 3'd1; cd = 16'h5555;
    cyc(); idle();
    cyc();
    check("R7", s_dr, 1'b1);
    rob_free = 0;
    cyc();
    check("R1", s_dr, 1'b0);
    rob_free = 1;

    // R8: flush with a dispatch in the same cycle
    flush = 1; dv = 1; ar = 1; br = 1; ddest = 3'd7;
    cyc(); idle();
    cyc();
    check("R8", s_iv, 1'b0);
    check("R8", s_dr, 1'b1);

    // mixed sweep of all ports against the model
    for (int n = 0; n < 4000; n++) begin
      dv = ($urandom % 2) == 0;
      dop = OW'($urandom); ddest = TW'($urandom);
      ar = ($urandom % 3) == 0; at = TW'($urandom); av = DW'($urandom);
      br = ($urandom % 3) == 0; bt = TW'($urandom); bv = DW'($urandom);
      cv = ($urandom % 2) == 0; ct = TW'($urandom); cd = DW'($urandom);
      ir = ($urandom % 10) < 7;
      rob_free = ($urandom % 10) < 8;
      flush = ($urandom % 64) == 0;
      cyc();
    end
    idle();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule